// File: doc/BRIEF.md
# Next Program Counter Unit

This block decides, within a single combinational step, which address a single-cycle 32-bit processor fetches next. It takes the current program counter, the sign-extended 16-bit immediate, the 26-bit jump field, the two register operands and a small amount of decoded control. From these it produces the next program counter and the incremented program counter. The incremented value is also the return address that the register file writes for a linking jump.

Four kinds of target compete for the next address. The first is a PC-relative branch, taken on operand equality, on operand inequality, or on the sign of the first operand alone. The second is a pseudo-direct jump built from the jump field. The third is a jump to the value held in a register. The fourth is a fixed system-call vector. When none of them applies, fetch moves on to the next word. The jump controls are separate bits. When more than one of them is raised, a fixed priority resolves the choice, and any jump overrides a branch.

Top module: `nxa_next_pc`

## Requirements
- R1: With `jump_sel_i` = 3'b000 and `br_kind_i` = 2'b00 (no branch), `next_pc_o` equals `pc_i` + 4.
- R2: `link_pc_o` always equals `pc_i` + 4 modulo 2^32, whatever the control inputs are.
- R3: With `br_kind_i` = 2'b01 (branch on equal), no jump bit set, and `rs_val_i` == `rt_val_i`, `next_pc_o` equals `pc_i` + 4 + (`imm_i` << 2), wrapping modulo 2^32, so a negative immediate moves backwards.
- R4: With `br_kind_i` = 2'b10 (branch on not-equal), no jump bit set, and `rs_val_i` != `rt_val_i`, `next_pc_o` equals `pc_i` + 4 + (`imm_i` << 2).
- R5: When a branch condition fails (equal-branch with unequal operands, or not-equal-branch with equal operands), `next_pc_o` equals `pc_i` + 4.
- R6: With `br_kind_i` = 2'b11 (branch on negative), the branch is taken exactly when bit 31 of `rs_val_i` is 1. `rt_val_i` has no effect on `next_pc_o`.
- R7: With `jump_sel_i` = 3'b001 (direct jump), `next_pc_o` = {(`pc_i`+4)[31:28], `jfield_i`, 2'b00}, regardless of branch control.
- R8: With `jump_sel_i` bit 1 set (register jump) and bit 2 clear, `next_pc_o` equals `rs_val_i`.
- R9: With `jump_sel_i` bit 2 set (system call), `next_pc_o` equals the `SYS_VECTOR` parameter, whose default is 32'h0000_0180.
- R10: Priority from highest to lowest is system call (bit 2), register jump (bit 1), direct jump (bit 0), branch, and sequential flow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| jfield_i | input | 26 | Address field of a direct jump |
| imm_i | input | 32 | Sign-extended 16-bit immediate, a word offset for branches |
| rs_val_i | input | 32 | Contents of the first source register |
| rt_val_i | input | 32 | Contents of the second source register |
| br_kind_i | input | 2 | Branch type: 00 none, 01 equal, 10 not-equal, 11 negative |
| jump_sel_i | input | 3 | Jump bits: [0] direct, [1] register, [2] system call |
| next_pc_o | output | 32 | Address to fetch next |
| link_pc_o | output | 32 | Current address plus 4, used as return address |

## Verification
A branch decision and a jump request can arrive in the same step, and so can two jump bits. The bench provokes this by drawing the jump bits at random across all eight patterns while the branch type and operands are also random. About half the draws force equal operands so that both equality outcomes occur often. A reference function applies the stated priority, and every overlapped case is judged by comparing `next_pc_o` against that function. Directed cases hold the branch condition true under each jump bit, to show that the jump wins.

// File: rtl/nxa_pkg.sv
package nxa_pkg;

    // Branch condition selector, matches br_kind_i encoding
    typedef enum logic [1:0] {
        BR_NONE = 2'b00,
        BR_EQ   = 2'b01,
        BR_NE   = 2'b10,
        BR_LTZ  = 2'b11
    } br_kind_e;

    // Bit positions inside jump_sel_i
    localparam int JSEL_DIRECT = 0;
    localparam int JSEL_REG    = 1;
    localparam int JSEL_VEC    = 2;
    localparam int JSEL_W      = 3;

    // Source chosen for the next address
    typedef enum logic [2:0] {
        SRC_SEQ    = 3'd0,
        SRC_BRANCH = 3'd1,
        SRC_DIRECT = 3'd2,
        SRC_REG    = 3'd3,
        SRC_VEC    = 3'd4
    } src_e;

endpackage

// File: rtl/nxa_branch_cond.sv
module nxa_branch_cond
    import nxa_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [XLEN-1:0] rt_val_i,
    input  br_kind_e        kind_i,
    output logic            taken_o
);

    typedef struct packed {
        logic same;
        logic neg;
        logic taken;
    } cond_t;

    cond_t cond_d;

    always_comb begin
        cond_d       = '0;
        cond_d.same  = (rs_val_i == rt_val_i);
        cond_d.neg   = rs_val_i[XLEN-1];
        unique case (kind_i)
            BR_EQ:   cond_d.taken = cond_d.same;
            BR_NE:   cond_d.taken = ~cond_d.same;
            BR_LTZ:  cond_d.taken = cond_d.neg;
            default: cond_d.taken = 1'b0;
        endcase
    end

    assign taken_o = cond_d.taken;

endmodule

// File: rtl/nxa_target_gen.sv
module nxa_target_gen #(
    parameter int XLEN  = 32,
    parameter int HI_W  = 4
) (
    input  logic [XLEN-1:0]        pc_i,
    input  logic [XLEN-HI_W-3:0]   jfield_i,
    input  logic [XLEN-1:0]        imm_i,
    output logic [XLEN-1:0]        link_o,
    output logic [XLEN-1:0]        br_tgt_o,
    output logic [XLEN-1:0]        dir_tgt_o
);

    localparam int          WORD_SHIFT = 2;
    localparam logic [XLEN-1:0] STEP   = XLEN'(4);

    typedef struct packed {
        logic [XLEN-1:0] link;
        logic [XLEN-1:0] offs;
        logic [XLEN-1:0] br;
        logic [XLEN-1:0] dir;
    } tgt_t;

    tgt_t tgt_d;

    always_comb begin
        tgt_d      = '0;
        tgt_d.link = pc_i + STEP;
        tgt_d.offs = {imm_i[XLEN-WORD_SHIFT-1:0], {WORD_SHIFT{1'b0}}};
        tgt_d.br   = tgt_d.link + tgt_d.offs;
        tgt_d.dir  = {tgt_d.link[XLEN-1 -: HI_W], jfield_i, {WORD_SHIFT{1'b0}}};
    end

    assign link_o    = tgt_d.link;
    assign br_tgt_o  = tgt_d.br;
    assign dir_tgt_o = tgt_d.dir;

endmodule

// File: rtl/nxa_next_sel.sv
module nxa_next_sel
    import nxa_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [JSEL_W-1:0] jump_sel_i,
    input  logic              taken_i,
    input  logic [XLEN-1:0]   link_i,
    input  logic [XLEN-1:0]   br_tgt_i,
    input  logic [XLEN-1:0]   dir_tgt_i,
    input  logic [XLEN-1:0]   reg_tgt_i,
    input  logic [XLEN-1:0]   vec_i,
    output logic [XLEN-1:0]   next_o
);

    typedef struct packed {
        src_e            src;
        logic [XLEN-1:0] addr;
    } sel_t;

    sel_t sel_d;

    always_comb begin
        sel_d = '{src: SRC_SEQ, addr: '0};
        // Highest priority first
        if (jump_sel_i[JSEL_VEC])         sel_d.src = SRC_VEC;
        else if (jump_sel_i[JSEL_REG])    sel_d.src = SRC_REG;
        else if (jump_sel_i[JSEL_DIRECT]) sel_d.src = SRC_DIRECT;
        else if (taken_i)                 sel_d.src = SRC_BRANCH;
        else                              sel_d.src = SRC_SEQ;

        unique case (sel_d.src)
            SRC_VEC:    sel_d.addr = vec_i;
            SRC_REG:    sel_d.addr = reg_tgt_i;
            SRC_DIRECT: sel_d.addr = dir_tgt_i;
            SRC_BRANCH: sel_d.addr = br_tgt_i;
            default:    sel_d.addr = link_i;
        endcase
    end

    assign next_o = sel_d.addr;

endmodule

// File: rtl/nxa_next_pc.sv
module nxa_next_pc
    import nxa_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          HI_W       = 4,
    parameter logic [31:0] SYS_VECTOR = 32'h0000_0180
) (
    input  logic [XLEN-1:0]      pc_i,
    input  logic [XLEN-HI_W-3:0] jfield_i,
    input  logic [XLEN-1:0]      imm_i,
    input  logic [XLEN-1:0]      rs_val_i,
    input  logic [XLEN-1:0]      rt_val_i,
    input  logic [1:0]           br_kind_i,
    input  logic [JSEL_W-1:0]    jump_sel_i,
    output logic [XLEN-1:0]      next_pc_o,
    output logic [XLEN-1:0]      link_pc_o
);

    localparam logic [XLEN-1:0] VEC = XLEN'(SYS_VECTOR);

    logic            taken;
    logic [XLEN-1:0] link;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] dir_tgt;

    nxa_branch_cond #(.XLEN(XLEN)) u_cond (
        .rs_val_i (rs_val_i),
        .rt_val_i (rt_val_i),
        .kind_i   (br_kind_e'(br_kind_i)),
        .taken_o  (taken)
    );

    nxa_target_gen #(.XLEN(XLEN), .HI_W(HI_W)) u_tgt (
        .pc_i      (pc_i),
        .jfield_i  (jfield_i),
        .imm_i     (imm_i),
        .link_o    (link),
        .br_tgt_o  (br_tgt),
        .dir_tgt_o (dir_tgt)
    );

    nxa_next_sel #(.XLEN(XLEN)) u_sel (
        .jump_sel_i (jump_sel_i),
        .taken_i    (taken),
        .link_i     (link),
        .br_tgt_i   (br_tgt),
        .dir_tgt_i  (dir_tgt),
        .reg_tgt_i  (rs_val_i),
        .vec_i      (VEC),
        .next_o     (next_pc_o)
    );

    assign link_pc_o = link;

    // Checks on the selector against the port-level rules
    always_comb begin
        if (!$isunknown({pc_i, jump_sel_i, br_kind_i, rs_val_i, rt_val_i})) begin
            p_link_step_r2: assert (link_pc_o - pc_i == XLEN'(4))
                else $error("link is not pc+4");
            if (jump_sel_i[JSEL_VEC])
                p_vector_wins_r9: assert (next_pc_o == VEC)
                    else $error("syscall vector not chosen");
            if (jump_sel_i[JSEL_REG] && !jump_sel_i[JSEL_VEC])
                p_reg_jump_r8: assert (next_pc_o == rs_val_i)
                    else $error("register jump target wrong");
            if (jump_sel_i == '0 && br_kind_i == 2'b00)
                p_sequential_r1: assert (next_pc_o == link_pc_o)
                    else $error("sequential flow broken");
            if (jump_sel_i == '0 && br_kind_i == 2'b11 && !rs_val_i[XLEN-1])
                p_ltz_positive_r6: assert (next_pc_o == link_pc_o)
                    else $error("negative-branch taken on non-negative rs");
            if (jump_sel_i == '0 && br_kind_i == 2'b01 && rs_val_i != rt_val_i)
                p_eq_fail_r5: assert (next_pc_o == link_pc_o)
                    else $error("equal-branch taken on unequal operands");
        end
    end

endmodule

// File: tb/sim_nxa_next_pc.sv
module sim_nxa_next_pc;

    logic        clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [31:0] pc, imm, rs, rt, nxt, lnk;
    logic [25:0] jf;
    logic [1:0]  bk;
    logic [2:0]  js;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    nxa_next_pc u0 (
        .pc_i (pc), .jfield_i (jf), .imm_i (imm),
        .rs_val_i (rs), .rt_val_i (rt),
        .br_kind_i (bk), .jump_sel_i (js),
        .next_pc_o (nxt), .link_pc_o (lnk)
    );

    function automatic logic [31:0] ref_next(
        input logic [31:0] p, input logic [25:0] f, input logic [31:0] im,
        input logic [31:0] a, input logic [31:0] b,
        input logic [1:0] k, input logic [2:0] s);
        logic [31:0] seq;
        logic        tk;
        seq = p + 32'd4;
        case (k)
            2'b01:   tk = (a == b);
            2'b10:   tk = (a != b);
            2'b11:   tk = a[31];
            default: tk = 1'b0;
        endcase
        if (s[2])      return 32'h0000_0180;
        else if (s[1]) return a;
        else if (s[0]) return {seq[31:28], f, 2'b00};
        else if (tk)   return seq + (im * 32'd4);
        else           return seq;
    endfunction

    function automatic string tag_of(input logic [31:0] a, input logic [31:0] b,
                                     input logic [1:0] k, input logic [2:0] s);
        if ($countones(s) > 1 || (s != 0 && k != 0)) return "R10";
        if (s[2]) return "R9";
        if (s[1]) return "R8";
        if (s[0]) return "R7";
        case (k)
            2'b01:   return (a == b) ? "R3" : "R5";
            2'b10:   return (a != b) ? "R4" : "R5";
            2'b11:   return "R6";
            default: return "R1";
        endcase
    endfunction

    task automatic apply(input logic [31:0] p, input logic [25:0] f,
                         input logic [31:0] im, input logic [31:0] a,
                         input logic [31:0] b, input logic [1:0] k,
                         input logic [2:0] s, input string req);
        logic [31:0] exp_n;
        @(posedge clk);
        pc = p; jf = f; imm = im; rs = a; rt = b; bk = k; js = s;
        @(negedge clk);
        exp_n = ref_next(p, f, im, a, b, k, s);
        checks++;
        if (nxt !== exp_n) begin
            fails++;
            $display("FAIL %s next_pc actual=%h expected=%h", req, nxt, exp_n);
        end
        checks++;
        if (lnk !== p + 32'd4) begin
            fails++;
            $display("FAIL R2 link_pc actual=%h expected=%h", lnk, p + 32'd4);
        end
    endtask

    function automatic logic [31:0] sx16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        pc = '0; jf = '0; imm = '0; rs = '0; rt = '0; bk = '0; js = '0;
        seed = $urandom(32'd2024);

        // Idle state: all-zero inputs, R1
        apply(32'h0, 26'h0, 32'h0, 32'h0, 32'h0, 2'b00, 3'b000, "R1");
        // R1 / R2 wrap at top of address space
        apply(32'hFFFF_FFFC, 26'h3, 32'h5, 32'h1, 32'h2, 2'b00, 3'b000, "R1");
        // R3 taken, positive and negative offsets
        apply(32'h0000_1000, 26'h0, sx16(16'h0010), 32'h55, 32'h55, 2'b01, 3'b000, "R3");
        apply(32'h0000_0100, 26'h0, sx16(16'hFFFF), 32'h7, 32'h7, 2'b01, 3'b000, "R3");
        apply(32'h0000_0000, 26'h0, sx16(16'h8000), 32'h0, 32'h0, 2'b01, 3'b000, "R3");
        // R5 not taken for both compare branches
        apply(32'h0000_2000, 26'h0, sx16(16'h0040), 32'h1, 32'h2, 2'b01, 3'b000, "R5");
        apply(32'h0000_2000, 26'h0, sx16(16'h0040), 32'h9, 32'h9, 2'b10, 3'b000, "R5");
        // R4 taken with negative offset
        apply(32'h0000_3000, 26'h0, sx16(16'hFFF0), 32'h1, 32'h0, 2'b10, 3'b000, "R4");
        // R6: sign bit decides, rt irrelevant
        apply(32'h0000_4000, 26'h0, sx16(16'hFFFE), 32'h8000_0000, 32'h8000_0000, 2'b11, 3'b000, "R6");
        apply(32'h0000_4000, 26'h0, sx16(16'hFFFE), 32'h8000_0000, 32'h0000_1234, 2'b11, 3'b000, "R6");
        apply(32'h0000_4000, 26'h0, sx16(16'h0004), 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b11, 3'b000, "R6");
        apply(32'h0000_4000, 26'h0, sx16(16'h0004), 32'h0, 32'hFFFF_FFFF, 2'b11, 3'b000, "R6");
        // R7: upper bits come from pc+4, crossing a region boundary
        apply(32'h7FFF_FFFC, 26'h3FF_FFFF, 32'h0, 32'h0, 32'h0, 2'b00, 3'b001, "R7");
        apply(32'h1234_5678, 26'h015_5555, 32'h0, 32'h0, 32'h0, 2'b00, 3'b001, "R7");
        // R8 and R9
        apply(32'h0000_5000, 26'h0, 32'h0, 32'hDEAD_BEE0, 32'h0, 2'b00, 3'b010, "R8");
        apply(32'h0000_6000, 26'h0, 32'h0, 32'h1, 32'h2, 2'b00, 3'b100, "R9");
        // R10: each jump bit beats a true branch, and higher bits beat lower
        apply(32'h0000_7000, 26'h1234, sx16(16'h0008), 32'hAA, 32'hAA, 2'b01, 3'b001, "R10");
        apply(32'h0000_7000, 26'h1234, sx16(16'h0008), 32'hAA, 32'hAA, 2'b01, 3'b011, "R10");
        apply(32'h0000_7000, 26'h1234, sx16(16'h0008), 32'hAA, 32'hAA, 2'b01, 3'b111, "R10");
        apply(32'h0000_7000, 26'h1234, sx16(16'h0008), 32'h8000_0000, 32'h0, 2'b11, 3'b110, "R10");

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a, b, p;
            logic [2:0]  s;
            logic [1:0]  k;
            p = $urandom() & 32'hFFFF_FFFC;
            a = $urandom();
            b = ($urandom() % 2 == 0) ? a : $urandom();
            k = 2'($urandom());
            s = ($urandom() % 3 == 0) ? 3'($urandom()) : 3'b000;
            apply(p, 26'($urandom()), sx16(16'($urandom())), a, b, k, s, tag_of(a, b, k, s));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule